// File: doc/BRIEF.md
# UART Receive FIFO Status and Interrupt Core

This block keeps the receive side state of a 16550-style serial port register set and produces its line status byte and receive-data interrupt. The receive shifter hands it characters, each with its parity, framing and break flags. The block stores each character together with its own flags, in a 16-entry FIFO or in a single holding register, depending on the mode. The host reads characters from the head, and can read the line status to learn about data, errors, overrun and the transmit side.

The host sets three things: the operating mode, a receive trigger level and a receive interrupt enable. In FIFO mode the interrupt follows the fill level against the trigger level in both directions, with no latching. In single-register mode it follows the occupancy of the holding register. With the enable clear, the host polls the status byte. The transmit side reaches the block only as two empty indications, which it folds into the status byte.

Top module: `uart_rx_status_core`

## Requirements
- R1: After reset the block is in single-register mode with the receive interrupt disabled and nothing stored. `irq` and `isr_trig` are 0, and `lsr` is 8'h60 while both transmit-empty inputs are 1.
- R2: In FIFO mode (`cfg_fifo_en`=1 written with `fcr_wr`) up to 16 characters are stored. `rhr_data` shows the oldest one, and each `rhr_rd` removes it, so characters leave in arrival order.
- R3: In single-register mode one character is stored. A second character that arrives before the host reads the first is an overrun.
- R4: `isr_trig` is 1 in FIFO mode while the stored count is at or above the trigger level, and 0 as soon as the count drops below it. `cfg_trig_sel` 0, 1, 2, 3 select levels 1, 4, 8, 14. In single-register mode `isr_trig` is 1 while a character is held.
- R5: `irq` equals `isr_trig` while the receive interrupt enable (`cfg_rx_ie` written with `ier_wr`) is 1, and stays 0 while the enable is 0 (polled mode).
- R6: `lsr[0]` is 1 from the cycle after a character is stored until the storage is empty.
- R7: A character that arrives while storage is full, with no read in the same cycle, is discarded. Stored contents are kept, and `lsr[1]` sets. `lsr[1]` clears on an `lsr_rd` pulse. If a new overrun and an `lsr_rd` pulse occur together, the bit stays set.
- R8: `lsr[2]`, `lsr[3]` and `lsr[4]` are the parity, framing and break flags of the character at the head. All three are 0 when storage is empty.
- R9: `lsr[5]` follows `tx_fifo_empty`. `lsr[6]` is 1 only when `tx_fifo_empty` and `tx_shift_empty` are both 1.
- R10: `lsr[7]` is 1 while any stored character, not only the head, carries at least one error flag.
- R11: A mode write that changes `cfg_fifo_en` empties the receive storage.
- R12: When storage is full, a push and a read in the same cycle are both taken, and no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receive shifter delivers a character this cycle |
| rx_char | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error flag of the delivered character |
| rx_ferr | input | 1 | Framing error flag of the delivered character |
| rx_brk | input | 1 | Break flag of the delivered character |
| rhr_rd | input | 1 | Host reads and removes the head character |
| lsr_rd | input | 1 | Host reads the line status (clears overrun) |
| ier_wr | input | 1 | Host writes the interrupt enable setting |
| cfg_rx_ie | input | 1 | Receive interrupt enable value for `ier_wr` |
| fcr_wr | input | 1 | Host writes the mode and trigger setting |
| cfg_fifo_en | input | 1 | FIFO mode value for `fcr_wr` |
| cfg_trig_sel | input | 2 | Trigger level select for `fcr_wr` |
| tx_fifo_empty | input | 1 | Transmit FIFO (or holding register) is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| rhr_data | output | 8 | Character at the head of receive storage |
| lsr | output | 8 | Line status byte |
| isr_trig | output | 1 | Receive level reached status |
| irq | output | 1 | Receive-data interrupt request |

## Verification
The assertions assume the host does not change the mode in the same cycle as a push or read. A mode change empties storage, and a push lost to that is not an overrun. The stimulus applies every configuration write on its own, in a cycle with no push or read. They also assume a read on empty storage is harmless and ignored; the bench reads only when data is expected. Pushes and reads are driven one per cycle on the falling edge. The only same-cycle push and read is the deliberate full-storage case.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_ent_t;

  function automatic logic ent_has_err(input rx_ent_t e);
    return e.perr | e.ferr | e.brk;
  endfunction
endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  rx_ent_t       push_ent,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [CW-1:0] err_cnt,
  output rx_ent_t       head,
  output logic          drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          pop_eff, room, wr_en, rd_en;

  assign pop_eff = pop && (count != '0);
  assign room    = (count < cap) || pop_eff;
  assign wr_en   = push && room && !flush;
  assign rd_en   = pop_eff && !flush;
  assign drop    = push && !room && !flush;
  assign head    = mem[rd_ptr];

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_ent;
  end

  logic inc_e, dec_e;
  assign inc_e = wr_en && ent_has_err(push_ent);
  assign dec_e = rd_en && ent_has_err(head);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      case ({inc_e, dec_e})
        2'b10:   err_cnt <= err_cnt + CW'(1);
        2'b01:   err_cnt <= err_cnt - CW'(1);
        default: err_cnt <= err_cnt;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_err_le_count_R10: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= count);
  assert_single_cap_R3: assert property (@(posedge clk) disable iff (rst)
    count <= cap);
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
  parameter int DEPTH   = 16,
  parameter int CW      = $clog2(DEPTH + 1),
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          rx_ie,
  input  logic [CW-1:0] count,
  output logic          isr_trig,
  output logic          irq
);
  logic [CW-1:0] level;

  always_comb begin
    case (trig_sel)
      2'd0:    level = CW'(TRIG_L0);
      2'd1:    level = CW'(TRIG_L1);
      2'd2:    level = CW'(TRIG_L2);
      default: level = CW'(TRIG_L3);
    endcase
  end

  assign isr_trig = fifo_en ? (count >= level) : (count != '0);
  assign irq      = rx_ie && isr_trig;

  assert_fifo_irq_data_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && isr_trig) |-> (count != '0));
endmodule

// File: rtl/uart_rx_status_core.sv
module uart_rx_status_core
  import uart_stat_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_push,
  input  logic [7:0] rx_char,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       rhr_rd,
  input  logic       lsr_rd,
  input  logic       ier_wr,
  input  logic       cfg_rx_ie,
  input  logic       fcr_wr,
  input  logic       cfg_fifo_en,
  input  logic [1:0] cfg_trig_sel,
  input  logic       tx_fifo_empty,
  input  logic       tx_shift_empty,
  output logic [7:0] rhr_data,
  output logic [7:0] lsr,
  output logic       isr_trig,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          fifo_en, rx_ie, overrun, flush, drop, nonempty;
  logic [1:0]    trig_sel;
  logic [CW-1:0] cap, ff_count, ff_err_cnt;
  rx_ent_t       in_ent, head;

  assign flush  = fcr_wr && (cfg_fifo_en != fifo_en);
  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign in_ent = '{data: rx_char, perr: rx_perr, ferr: rx_ferr, brk: rx_brk};

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en  <= 1'b0;
      trig_sel <= 2'd0;
      rx_ie    <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (ier_wr) rx_ie <= cfg_rx_ie;
      if (fcr_wr) begin
        fifo_en  <= cfg_fifo_en;
        trig_sel <= cfg_trig_sel;
      end
      if (drop)        overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
    end
  end

  rx_char_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .cap(cap),
    .push(rx_push), .push_ent(in_ent), .pop(rhr_rd),
    .count(ff_count), .err_cnt(ff_err_cnt), .head(head), .drop(drop)
  );

  rx_irq_gen #(.DEPTH(DEPTH), .CW(CW), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
               .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3)) u_irq (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_ie(rx_ie), .count(ff_count), .isr_trig(isr_trig), .irq(irq)
  );

  assign nonempty = (ff_count != '0);
  assign rhr_data = nonempty ? head.data : 8'h00;
  assign lsr = {ff_err_cnt != '0,
                tx_fifo_empty && tx_shift_empty,
                tx_fifo_empty,
                nonempty && head.brk,
                nonempty && head.ferr,
                nonempty && head.perr,
                overrun,
                nonempty};

  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_push && ff_count == cap && !(rhr_rd && nonempty) && !flush) |=> lsr[1]);
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_push && ff_count == cap && !rhr_rd && !flush) |=> ff_count == $past(ff_count));
  assert_full_rw_no_ovr_R12: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rhr_rd && nonempty && !flush && !lsr_rd && !lsr[1]) |=> !lsr[1]);
endmodule

// File: tb/tb_uart_rx_status_core.sv
module tb_uart_rx_status_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0] rx_char = 0;
  logic       rhr_rd = 0, lsr_rd = 0, ier_wr = 0, cfg_rx_ie = 0;
  logic       fcr_wr = 0, cfg_fifo_en = 0;
  logic [1:0] cfg_trig_sel = 0;
  logic       tx_fifo_empty = 1, tx_shift_empty = 1;
  logic [7:0] rhr_data, lsr;
  logic       isr_trig, irq;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_rx_status_core dut (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_char(rx_char),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rhr_rd(rhr_rd), .lsr_rd(lsr_rd), .ier_wr(ier_wr), .cfg_rx_ie(cfg_rx_ie),
    .fcr_wr(fcr_wr), .cfg_fifo_en(cfg_fifo_en), .cfg_trig_sel(cfg_trig_sel),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .rhr_data(rhr_data), .lsr(lsr), .isr_trig(isr_trig), .irq(irq)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    rx_push = 1; rx_char = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    @(negedge clk);
    rx_push = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic rd();
    @(negedge clk); rhr_rd = 1;
    @(negedge clk); rhr_rd = 0;
  endtask

  task automatic read_lsr();
    @(negedge clk); lsr_rd = 1;
    @(negedge clk); lsr_rd = 0;
  endtask

  task automatic set_fcr(input logic en, input logic [1:0] sel);
    @(negedge clk); fcr_wr = 1; cfg_fifo_en = en; cfg_trig_sel = sel;
    @(negedge clk); fcr_wr = 0;
  endtask

  task automatic set_ier(input logic ie);
    @(negedge clk); ier_wr = 1; cfg_rx_ie = ie;
    @(negedge clk); ier_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 lsr after reset", lsr, 8'h60);
    chk("R1 irq after reset", irq, 0);
    chk("R1 isr_trig after reset", isr_trig, 0);
  endtask

  task automatic t_tx();
    tx_fifo_empty = 0; tx_shift_empty = 1; #1;
    chk("R9 lsr[6:5] tx busy", lsr[6:5], 2'b00);
    tx_fifo_empty = 1; tx_shift_empty = 0; #1;
    chk("R9 lsr[6:5] shifter busy", lsr[6:5], 2'b01);
    tx_shift_empty = 1; #1;
    chk("R9 lsr[6:5] all empty", lsr[6:5], 2'b11);
  endtask

  task automatic t_single();
    set_ier(1);
    push(8'h41, 0, 0, 0);
    chk("R6 data ready", lsr[0], 1);
    chk("R4 isr single mode", isr_trig, 1);
    chk("R5 irq single mode", irq, 1);
    push(8'h42, 0, 0, 0);
    chk("R3 overrun in single mode", lsr[1], 1);
    chk("R3 first char kept", rhr_data, 8'h41);
    read_lsr();
    chk("R7 overrun cleared by lsr read", lsr[1], 0);
    rd();
    chk("R6 data ready clears", lsr[0], 0);
    chk("R5 irq clears", irq, 0);
  endtask

  task automatic t_polled();
    set_ier(0);
    push(8'h55, 0, 0, 0);
    chk("R5 polled isr", isr_trig, 1);
    chk("R5 polled irq low", irq, 0);
    rd();
  endtask

  task automatic t_fifo_order();
    set_fcr(1, 2'd0);
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 0, 0, 0);
    chk("R7 no overrun at 16", lsr[1], 0);
    push(8'hEE, 0, 0, 0);
    chk("R7 overrun at 17th", lsr[1], 1);
    for (int i = 0; i < 16; i++) begin
      chk("R2 order / R7 contents kept", rhr_data, 8'h10 + 8'(i));
      rd();
    end
    chk("R2 empty after drain", lsr[0], 0);
    @(negedge clk); lsr_rd = 1; rx_push = 1; rx_char = 8'h01;
    @(negedge clk); lsr_rd = 0; rx_push = 0;
    chk("R7 lsr read without overrun clears", lsr[1], 0);
    rd();
  endtask

  task automatic t_full_rw();
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 0, 0, 0);
    @(negedge clk); rx_push = 1; rx_char = 8'h99; rhr_rd = 1;
    @(negedge clk); rx_push = 0; rhr_rd = 0;
    chk("R12 no overrun on push+read", lsr[1], 0);
    for (int i = 1; i < 16; i++) begin
      chk("R12 order after push+read", rhr_data, 8'h40 + 8'(i));
      rd();
    end
    chk("R12 new char stored", rhr_data, 8'h99);
    rd();
  endtask

  task automatic t_trigger();
    int lv [4] = '{1, 4, 8, 14};
    set_ier(1);
    for (int s = 0; s < 4; s++) begin
      set_fcr(1, 2'(s));
      for (int i = 0; i < lv[s] - 1; i++) push(8'(i), 0, 0, 0);
      chk("R4 below level", isr_trig, 0);
      push(8'hA0, 0, 0, 0);
      chk("R4 at level", isr_trig, 1);
      chk("R5 irq at level", irq, 1);
      rd();
      chk("R4 drops below level", isr_trig, 0);
      chk("R5 irq drops", irq, 0);
      for (int i = 0; i < lv[s] - 1; i++) rd();
    end
  endtask

  task automatic t_errors();
    push(8'h01, 0, 0, 0);
    push(8'h02, 1, 0, 0);
    push(8'h03, 0, 1, 0);
    push(8'h04, 0, 0, 1);
    chk("R8 clean head", lsr[4:2], 3'b000);
    chk("R10 error deeper in fifo", lsr[7], 1);
    rd(); chk("R8 parity head", lsr[4:2], 3'b001);
    rd(); chk("R8 framing head", lsr[4:2], 3'b010);
    rd(); chk("R8 break head", lsr[4:2], 3'b100);
    chk("R10 last error stored", lsr[7], 1);
    rd();
    chk("R8 empty clears flags", lsr[4:2], 3'b000);
    chk("R10 no errors stored", lsr[7], 0);
  endtask

  task automatic t_flush();
    push(8'h11, 0, 0, 0); push(8'h12, 0, 0, 0); push(8'h13, 0, 0, 0);
    set_fcr(0, 2'd0);
    chk("R11 mode change empties", lsr[0], 0);
    chk("R11 isr after flush", isr_trig, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_tx();
    t_single();
    t_polled();
    t_fifo_order();
    t_full_rw();
    t_trigger();
    t_errors();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule